// File: doc/BRIEF.md
# Segment Selector Translation Unit

This block turns a two-part address, made of a segment register slot and a byte offset, into a 32-bit linear address. It keeps a small cache of segment descriptors. Each slot holds a 16-bit selector, a 32-bit base, a 20-bit limit, a granularity flag and a present flag. Software or a descriptor fetcher fills a slot through a single-cycle load port. The fetching of descriptors from memory happens outside this block.

On an access, the block reads the chosen slot. It checks the selector and the present flag, and it compares the offset with the limit after the limit has been scaled by granularity. One cycle later it returns either the base-plus-offset address or a fault code. When paging is switched off, the same address is also given out as the physical address.

Alongside this, the block decodes the selector on the load port into the byte address of its 8-byte descriptor. This helps whatever fetches that descriptor.

Top module: `seg_xlate`

## Requirements
- R1: `desc_addr` is combinational. It equals `ldt_base` when `ld_sel` bit 2 is 1, or `gdt_base` when bit 2 is 0, plus `ld_sel` with its three low bits forced to zero, modulo 2^32. For example, selector 72 gives `gdt_base`+72.
- R2: A load with `ld_en` high and `ld_slot` below 6 replaces all five fields of that slot at the clock edge. A load to slot 6 or 7 changes nothing: an access to those slots still reports the null fault.
- R3: A selector is null when bits 15..2 are all zero, which means global table entry 0. Such a selector may be loaded, but an access through it gives `fault`=1 (null). This check takes priority over the other faults. A selector with bit 2 set and index 0 is not null.
- R4: An access to a non-null slot whose present flag is 0 gives `fault`=2 (not present). This check takes priority over the limit check.
- R5: With granularity 0, an offset that is less than or equal to the limit is legal. An offset above the limit gives `fault`=3 (limit).
- R6: With granularity 1, the effective limit is limit*4096+4095. Offsets up to and including that value are legal, and offsets beyond it give `fault`=3.
- R7: On a legal access, `lin_valid` is 1 and `lin_addr` equals base+offset modulo 2^32, one clock after `acc_en`.
- R8: After a legal access with `paging_en` low, `phys_valid` is 1 and `phys_addr` equals `lin_addr`. With `paging_en` high, `phys_valid` is 0 and `phys_addr` is 0.
- R9: In a cycle after a faulting access, or after a cycle without `acc_en`, `lin_valid`, `phys_valid`, `lin_addr` and `phys_addr` are 0. `fault` is 0 after a cycle without `acc_en`.
- R10: After reset, all registered outputs are 0 and every slot holds a null selector, so an access to any slot gives `fault`=1.
- R11: An access and a load to the same slot in the same cycle see the slot contents from before the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gdt_base | input | 32 | Byte base of the global descriptor table |
| ldt_base | input | 32 | Byte base of the local descriptor table |
| ld_en | input | 1 | Write the load port fields into a slot |
| ld_slot | input | 3 | Slot written by the load |
| ld_sel | input | 16 | Selector loaded, also decoded for desc_addr |
| ld_base | input | 32 | Segment base loaded |
| ld_limit | input | 20 | Segment limit loaded |
| ld_gran | input | 1 | Limit unit: 0 byte, 1 4 KB page |
| ld_present | input | 1 | Segment present flag loaded |
| desc_addr | output | 32 | Byte address of the descriptor named by ld_sel |
| acc_en | input | 1 | Access request this cycle |
| acc_slot | input | 3 | Slot used by the access |
| acc_off | input | 32 | Offset within the segment |
| paging_en | input | 1 | 1 keeps the linear address off the physical output |
| lin_valid | output | 1 | Linear address valid |
| lin_addr | output | 32 | Linear address |
| phys_valid | output | 1 | Physical address valid (paging off) |
| phys_addr | output | 32 | Physical address |
| fault | output | 2 | 0 none, 1 null, 2 not present, 3 limit |

## Verification
The hardest conditions to reach are the exact edges of the bounds check with a scaled limit, and the priority between the fault causes. To reach them, slots are loaded with limits whose effective value lands exactly on a page boundary. The accesses then probe the offset at that value and at that value plus one, and include an offset of all ones against the largest possible limit. Other slots carry both a null selector and a cleared present flag, so the priority order can be seen, and a local-table index-0 selector shows that it is not treated as null. A load and an access to the same slot are also issued in the same cycle, so the bench can tell the old contents from the new ones.

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int SLOTS = 6,
  parameter int SW    = 3,
  parameter int AW    = 32,
  parameter int LW    = 20,
  parameter int PG    = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] gdt_base,
  input  logic [AW-1:0] ldt_base,
  input  logic          ld_en,
  input  logic [SW-1:0] ld_slot,
  input  logic [15:0]   ld_sel,
  input  logic [AW-1:0] ld_base,
  input  logic [LW-1:0] ld_limit,
  input  logic          ld_gran,
  input  logic          ld_present,
  output logic [AW-1:0] desc_addr,
  input  logic          acc_en,
  input  logic [SW-1:0] acc_slot,
  input  logic [AW-1:0] acc_off,
  input  logic          paging_en,
  output logic          lin_valid,
  output logic [AW-1:0] lin_addr,
  output logic          phys_valid,
  output logic [AW-1:0] phys_addr,
  output logic [1:0]    fault
);
  localparam int NS = 2 ** SW;
  localparam logic [1:0] F_NONE = 2'd0, F_NULL = 2'd1, F_NP = 2'd2, F_LIM = 2'd3;

  logic [15:0]   sel_q  [NS];
  logic [AW-1:0] base_q [NS];
  logic [LW-1:0] lim_q  [NS];
  logic [NS-1:0] gran_q, pres_q;

  assign desc_addr = (ld_sel[2] ? ldt_base : gdt_base) + AW'({ld_sel[15:3], 3'b000});

  logic [15:0]   r_sel;
  logic [AW-1:0] r_eff, sum;
  logic [1:0]    cause;
  logic          ok;

  assign r_sel = sel_q[acc_slot];
  assign r_eff = gran_q[acc_slot] ? AW'({lim_q[acc_slot], {PG{1'b1}}}) : AW'(lim_q[acc_slot]);
  assign sum   = base_q[acc_slot] + acc_off;

  always_comb begin
    if (r_sel[15:2] == '0)         cause = F_NULL;
    else if (!pres_q[acc_slot])    cause = F_NP;
    else if (acc_off > r_eff)      cause = F_LIM;
    else                           cause = F_NONE;
  end
  assign ok = acc_en && (cause == F_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NS; i++) begin
        sel_q[i]  <= '0;
        base_q[i] <= '0;
        lim_q[i]  <= '0;
      end
      gran_q <= '0;
      pres_q <= '0;
    end else if (ld_en && (int'(ld_slot) < SLOTS)) begin
      sel_q[ld_slot]  <= ld_sel;
      base_q[ld_slot] <= ld_base;
      lim_q[ld_slot]  <= ld_limit;
      gran_q[ld_slot] <= ld_gran;
      pres_q[ld_slot] <= ld_present;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lin_valid  <= 1'b0;
      lin_addr   <= '0;
      phys_valid <= 1'b0;
      phys_addr  <= '0;
      fault      <= F_NONE;
    end else begin
      lin_valid  <= ok;
      lin_addr   <= ok ? sum : '0;
      phys_valid <= ok && !paging_en;
      phys_addr  <= (ok && !paging_en) ? sum : '0;
      fault      <= acc_en ? cause : F_NONE;
    end
  end

  p_fault_no_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fault != F_NONE) |-> (!lin_valid && !phys_valid));
  p_phys_follows_lin_r8: assert property (@(posedge clk) disable iff (!rst_n)
    phys_valid |-> (lin_valid && phys_addr == lin_addr));
  p_paging_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && paging_en) |=> !phys_valid);
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_en |=> (!lin_valid && fault == F_NONE && lin_addr == '0));
  p_null_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && sel_q[acc_slot][15:2] == '0) |=> (fault == F_NULL));
  p_high_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(acc_slot) >= SLOTS && acc_en) |=> (fault == F_NULL));
endmodule

// File: tb/test_seg_xlate.sv
module test_seg_xlate;
  localparam int PER = 10;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] gdt_base = 32'h0001_0000, ldt_base = 32'h0002_0000;
  logic ld_en = 0, ld_gran = 0, ld_present = 0;
  logic [2:0] ld_slot = 0, acc_slot = 0;
  logic [15:0] ld_sel = 0;
  logic [31:0] ld_base = 0, acc_off = 0;
  logic [19:0] ld_limit = 0;
  logic acc_en = 0, paging_en = 0;
  logic [31:0] desc_addr, lin_addr, phys_addr;
  logic lin_valid, phys_valid;
  logic [1:0] fault;

  seg_xlate i_seg_xlate (.*);

  always #(PER/2) clk = ~clk;

  int checks = 0, errors = 0;
  string cur = "R10";
  bit done = 0;

  logic [15:0] m_sel [8];
  logic [31:0] m_base [8];
  longint m_lim [8];
  bit m_gran [8], m_pres [8];
  bit e_lv, e_pv;
  logic [31:0] e_la, e_pa;
  logic [1:0] e_f;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin
        m_sel[i] = 0; m_base[i] = 0; m_lim[i] = 0; m_gran[i] = 0; m_pres[i] = 0;
      end
      e_lv = 0; e_pv = 0; e_la = 0; e_pa = 0; e_f = 0;
    end else begin
      longint eff, s;
      int k;
      k = acc_slot;
      eff = m_gran[k] ? m_lim[k] * 4096 + 4095 : m_lim[k];
      s = (longint'(m_base[k]) + longint'(acc_off)) % 64'h1_0000_0000;
      e_f = 0;
      if (acc_en) begin
        if (m_sel[k] / 4 == 0) e_f = 1;
        else if (!m_pres[k]) e_f = 2;
        else if (longint'(acc_off) > eff) e_f = 3;
      end
      e_lv = acc_en && e_f == 0;
      e_la = e_lv ? s[31:0] : 0;
      e_pv = e_lv && !paging_en;
      e_pa = e_pv ? s[31:0] : 0;
      if (ld_en && ld_slot < 6) begin
        k = ld_slot;
        m_sel[k] = ld_sel; m_base[k] = ld_base; m_lim[k] = ld_limit;
        m_gran[k] = ld_gran; m_pres[k] = ld_present;
      end
    end
  end

  task automatic compare();
    checks++;
    if (lin_valid !== e_lv || lin_addr !== e_la || phys_valid !== e_pv ||
        phys_addr !== e_pa || fault !== e_f) begin
      errors++;
      $display("FAIL %s: got lv=%0b la=%h pv=%0b pa=%h f=%0d exp lv=%0b la=%h pv=%0b pa=%h f=%0d",
               cur, lin_valid, lin_addr, phys_valid, phys_addr, fault,
               e_lv, e_la, e_pv, e_pa, e_f);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    compare();
    ld_en = 0; acc_en = 0;
  endtask

  task automatic load(input logic [2:0] sl, input logic [15:0] sel, input logic [31:0] b,
                      input logic [19:0] lim, input bit g, input bit p);
    ld_en = 1; ld_slot = sl; ld_sel = sel; ld_base = b; ld_limit = lim;
    ld_gran = g; ld_present = p;
    cyc();
  endtask

  task automatic acc(input logic [2:0] sl, input logic [31:0] off, input bit pg);
    acc_en = 1; acc_slot = sl; acc_off = off; paging_en = pg;
    cyc();
    cyc();
  endtask

  task automatic chk_desc(input logic [15:0] sel, input logic [31:0] exp);
    ld_sel = sel;
    #1;
    checks++;
    if (desc_addr !== exp) begin
      errors++;
      $display("FAIL R1: sel=%h got %h exp %h", sel, desc_addr, exp);
    end
  endtask

  initial begin
    #(PER * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout exp finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare();                 // R10 outputs zero in reset
    rst_n = 1;
    cyc();
    cur = "R10"; acc(0, 0, 0); acc(5, 0, 0);
    cur = "R1";
    chk_desc(16'd72, 32'h0001_0048);
    chk_desc(16'h004F, 32'h0002_0048);
    chk_desc(16'hFFFB, 32'h0001_FFF8);
    cur = "R2";
    load(1, 16'h0010, 32'h1000_0000, 20'h00FFF, 0, 1);
    load(2, 16'h001C, 32'h2000_0000, 20'h00003, 1, 1);
    load(3, 16'h0018, 32'h3000_0000, 20'hFFFFF, 0, 0);
    load(4, 16'h0004, 32'hFFFF_F000, 20'hFFFFF, 1, 1);
    load(6, 16'h0020, 32'h4000_0000, 20'hFFFFF, 1, 1);
    load(7, 16'h0020, 32'h4000_0000, 20'hFFFFF, 1, 1);
    acc(6, 32'h10, 0); acc(7, 32'h10, 0);   // R2 ignored slots stay null
    cur = "R7"; acc(1, 32'h0000_0123, 0);
    cur = "R5"; acc(1, 32'h0000_0FFF, 0); acc(1, 32'h0000_1000, 0);
    cur = "R6"; acc(2, 32'h0000_3FFF, 0); acc(2, 32'h0000_4000, 0);
    cur = "R4"; acc(3, 32'h0, 0);
    cur = "R3"; load(0, 16'h0003, 32'h5000_0000, 20'hFFFFF, 0, 0); acc(0, 32'h0, 0);
    load(5, 16'h0000, 32'h5000_0000, 20'hFFFFF, 1, 1); acc(5, 32'h1, 0);
    cur = "R7"; acc(4, 32'h0000_2000, 0); acc(4, 32'hFFFF_FFFF, 0);  // wrap, max limit
    cur = "R8"; acc(1, 32'h44, 1); acc(2, 32'h100, 1); acc(1, 32'h44, 0);
    cur = "R9"; acc(1, 32'h2000, 0); cyc();
    cur = "R11";
    ld_en = 1; ld_slot = 1; ld_sel = 16'h0008; ld_base = 32'h7000_0000; ld_limit = 20'h0;
    ld_gran = 0; ld_present = 0;
    acc_en = 1; acc_slot = 1; acc_off = 32'h10; paging_en = 0;
    cyc(); cyc();
    acc(1, 32'h10, 0);
    cur = "R6"; load(2, 16'h001C, 32'h0, 20'h00000, 1, 1);
    acc(2, 32'h0FFF, 0); acc(2, 32'h1000, 0);
    cur = "R1"; chk_desc(16'h0007, 32'h0002_0000);
    for (int i = 0; i < 40; i++) begin
      cur = "R7";
      acc_en = (i % 3) != 0; acc_slot = 3'(i % 8); acc_off = 32'(i * 32'h0000_0931);
      paging_en = (i % 5) == 0;
      cyc();
    end
    cyc();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule